// File: doc/BRIEF.md
# Flash Security Access Guard

This block sits between the agents that reach the on-chip code flash and the flash controller and rules on every access. Each request gives the access mode, the operation and, for reads and fetches, whether the instruction behind it is running from external code memory. The block keeps three security bits (write lock, read lock and external-run lock) and answers every request with a registered grant or deny one clock after the request strobe. Any denial latches a sticky violation flag, which software clears through a dedicated input.

The security bits matter only while the flash is driven by an external programmer (parallel or in-system). In application programming mode they are bypassed, but their state can be read back with a query operation. One rule ignores the bits: a table read issued by code running from external memory may never return bytes from internal code. A chip erase clears all three bits along with the user array. Program requests are the only way to set a bit. Reset reloads the bits from a parameter that stands in for their nonvolatile image.

Top module: `flash_sec_guard`

## Requirements
- R1: A request with `req_valid` high on a rising edge produces `rsp_valid` high for exactly the following cycle, carrying the verdict on `rsp_grant`. With no request, `rsp_valid` and `rsp_grant` are low.
- R2: Mode codes are parallel programmer 0, in-system 1, application 2 and run 3. In modes 0 and 1, page erase (op 1) and program (op 2) are denied while the write lock (bit 0) is set. Security-bit program (op 3) and chip erase (op 4) are still granted.
- R3: In modes 0 and 1, read (op 0) is denied while the read lock (bit 1) is set. It is granted otherwise, whatever `req_ext` is.
- R4: In modes 0, 1 and 3, fetch (op 5) with `req_ext`=1 is denied while the external-run lock (bit 2) is set. A fetch with `req_ext`=0 is always granted.
- R5: In mode 2 the security bits have no effect. Ops 1 to 5 are granted, and read is granted when `req_ext`=0.
- R6: A read (op 0) with `req_ext`=1 in mode 2 or 3 is denied for every security-bit state.
- R7: Query (op 6) is granted only in mode 2. Its response puts the bits on `rsp_bits` (bit 0 write lock, bit 1 read lock, bit 2 external-run lock). Every other response drives `rsp_bits` to 0.
- R8: A granted op 3 sets the bit selected by `req_sel` (0, 1, 2 select bits 0, 1, 2). It is granted in modes 0, 1 and 2, and denied when `req_sel`=3. Ops 1 to 4 are denied in mode 3, and op 7 is always denied. Bits are never cleared except by R9.
- R9: A granted chip erase clears all three bits. The new state is visible to a query issued on the next cycle.
- R10: A denied request sets `viol`, which holds until `viol_clr` is high with no new denial. If a denial and `viol_clr` fall on the same edge, `viol` stays set.
- R11: Reset clears `rsp_valid`, `rsp_grant`, `rsp_bits` and `viol`, and loads the bits from `RESET_BITS` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | Access mode code |
| req_op | input | 3 | Operation code |
| req_ext | input | 1 | Issuing code runs from external memory / fetch targets external memory |
| req_sel | input | SEL_W (2) | Security bit selector for op 3 |
| viol_clr | input | 1 | Clear the sticky violation flag |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_grant | output | 1 | 1 grant, 0 deny |
| rsp_bits | output | 3 | Security bit state on a granted query, else 0 |
| viol | output | 1 | Sticky violation flag |

## Verification
A denied request and a software clear of the violation flag can arrive on the same clock edge, and the flag must come out set. The bench provokes this by driving `viol_clr` together with a program request in run mode, which is always refused. It then drives the clear together with a granted read and checks that the flag does drop. A second overlap is a security-bit program followed at once by a query. This shows that a bit changes on the same edge that grants its program request.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int SEC_N = 3;

   typedef enum logic [1:0] {
      MD_PAR = 2'd0,
      MD_ISP = 2'd1,
      MD_IAP = 2'd2,
      MD_RUN = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PERASE = 3'd1,
      OP_PROG   = 3'd2,
      OP_PSEC   = 3'd3,
      OP_CERASE = 3'd4,
      OP_FETCH  = 3'd5,
      OP_QUERY  = 3'd6,
      OP_RSVD   = 3'd7
   } op_e;

   typedef struct packed {
      logic xinh;
      logic rdp;
      logic wrp;
   } sec_t;
endpackage

// File: rtl/fsg_decide.sv
module fsg_decide
   import fsg_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             valid,
   input  mode_e            mode,
   input  op_e              op,
   input  logic             ext,
   input  logic [SEL_W-1:0] sel,
   input  sec_t             sec,
   output logic             grant,
   output logic             query,
   output logic [SEC_N-1:0] set_mask,
   output logic             clr_all
);
   logic in_prog;
   logic in_iap;
   logic sel_ok;
   logic verdict;

   assign in_prog = (mode == MD_PAR) || (mode == MD_ISP);
   assign in_iap  = (mode == MD_IAP);
   assign sel_ok  = (int'(sel) < SEC_N);

   always_comb begin
      verdict = 1'b0;
      case (op)
         OP_READ:            verdict = in_prog ? !sec.rdp : !ext;
         OP_PERASE, OP_PROG: verdict = in_prog ? !sec.wrp : in_iap;
         OP_PSEC:            verdict = (in_prog || in_iap) && sel_ok;
         OP_CERASE:          verdict = in_prog || in_iap;
         OP_FETCH:           verdict = in_iap ? 1'b1 : !(ext && sec.xinh);
         OP_QUERY:           verdict = in_iap;
         default:            verdict = 1'b0;
      endcase
   end

   assign grant   = valid && verdict;
   assign query   = grant && (op == OP_QUERY);
   assign clr_all = grant && (op == OP_CERASE);

   for (genvar i = 0; i < SEC_N; i++) begin : g_set
      assign set_mask[i] = grant && (op == OP_PSEC) && (int'(sel) == i);
   end
endmodule

// File: rtl/fsg_sec_store.sv
module fsg_sec_store
   import fsg_pkg::*;
#(
   parameter logic [SEC_N-1:0] RESET_BITS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_N-1:0] set_mask,
   input  logic             clr_all,
   output logic [SEC_N-1:0] bits_q
);
   for (genvar i = 0; i < SEC_N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           bits_q[i] <= RESET_BITS[i];
         else if (clr_all)     bits_q[i] <= 1'b0;
         else if (set_mask[i]) bits_q[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/fsg_viol.sv
module fsg_viol #(
   parameter bit CLR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic nxt;

   if (CLR_WINS) begin : g_clr_first
      assign nxt = clr ? 1'b0 : (set | flag);
   end else begin : g_set_first
      assign nxt = set ? 1'b1 : (flag & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= nxt;
   end
endmodule

// File: rtl/flash_sec_guard.sv
module flash_sec_guard
   import fsg_pkg::*;
#(
   parameter int               SEL_W         = 2,
   parameter logic [SEC_N-1:0] RESET_BITS    = '0,
   parameter bit               VIOL_CLR_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_mode,
   input  logic [2:0]       req_op,
   input  logic             req_ext,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             viol_clr,
   output logic             rsp_valid,
   output logic             rsp_grant,
   output logic [SEC_N-1:0] rsp_bits,
   output logic             viol
);
   localparam int SEL_MIN = $clog2(SEC_N);

   if (SEL_W < SEL_MIN) begin : g_bad_sel
      $error("SEL_W too narrow to address every security bit");
   end

   logic [SEC_N-1:0] sec_q;
   logic [SEC_N-1:0] set_mask;
   logic             clr_all;
   logic             grant_c;
   logic             query_c;
   logic             deny_c;

   fsg_decide #(.SEL_W(SEL_W)) u_decide (
      .valid    (req_valid),
      .mode     (mode_e'(req_mode)),
      .op       (op_e'(req_op)),
      .ext      (req_ext),
      .sel      (req_sel),
      .sec      (sec_t'(sec_q)),
      .grant    (grant_c),
      .query    (query_c),
      .set_mask (set_mask),
      .clr_all  (clr_all)
   );

   fsg_sec_store #(.RESET_BITS(RESET_BITS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_all  (clr_all),
      .bits_q   (sec_q)
   );

   assign deny_c = req_valid && !grant_c;

   fsg_viol #(.CLR_WINS(VIOL_CLR_WINS)) u_viol (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (deny_c),
      .clr   (viol_clr),
      .flag  (viol)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_bits  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= grant_c;
         rsp_bits  <= query_c ? sec_q : '0;
      end
   end
endmodule

// File: rtl/fsg_guard_chk.sv
module fsg_guard_chk #(
   parameter int SEL_W         = 2,
   parameter bit VIOL_CLR_WINS = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_mode,
   input logic [2:0]       req_op,
   input logic             req_ext,
   input logic [SEL_W-1:0] req_sel,
   input logic             viol_clr,
   input logic             rsp_valid,
   input logic             rsp_grant,
   input logic [2:0]       rsp_bits,
   input logic             viol,
   input logic [2:0]       sec_q
);
   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_grant));

   // R6
   ext_table_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd0 && req_ext && req_mode[1]) |=> !rsp_grant);

   // R7
   bits_only_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_bits != 3'b000) |-> (rsp_valid && rsp_grant));

   // R8
   bit_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sec_q & ~$past(sec_q)) != 3'b000) |-> $past(req_valid && req_op == 3'd3));

   // R9
   bit_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~sec_q & $past(sec_q)) != 3'b000) |-> ($past(req_valid && req_op == 3'd4) && sec_q == 3'b000));

   // R10
   viol_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(viol) |-> $past(viol_clr));

   // R10
   viol_on_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant && !VIOL_CLR_WINS) |-> viol);
endmodule

bind flash_sec_guard fsg_guard_chk #(.SEL_W(SEL_W), .VIOL_CLR_WINS(VIOL_CLR_WINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_mode  (req_mode),
   .req_op    (req_op),
   .req_ext   (req_ext),
   .req_sel   (req_sel),
   .viol_clr  (viol_clr),
   .rsp_valid (rsp_valid),
   .rsp_grant (rsp_grant),
   .rsp_bits  (rsp_bits),
   .viol      (viol),
   .sec_q     (sec_q)
);

// File: tb/flash_sec_guard_test.sv
`timescale 1ns/1ps
module flash_sec_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = '0;
   logic [2:0] req_op = '0;
   logic       req_ext = 1'b0;
   logic [1:0] req_sel = '0;
   logic       viol_clr = 1'b0;
   logic       rsp_valid;
   logic       rsp_grant;
   logic [2:0] rsp_bits;
   logic       viol;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_sec_guard uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_op(req_op), .req_ext(req_ext), .req_sel(req_sel), .viol_clr(viol_clr),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_bits(rsp_bits), .viol(viol)
   );

   // {mode[11:10], op[9:7], ext[6], sel[5:4], grant[3], bits[2:0]}
   localparam int NV = 27;
   localparam logic [11:0] VEC [NV] = '{
      {2'd2, 3'd6, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd0, 3'd0, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd0, 3'd2, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd3, 3'd0, 1'b1, 2'd0, 1'b0, 3'b000},
      {2'd2, 3'd0, 1'b1, 2'd0, 1'b0, 3'b000},
      {2'd2, 3'd0, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd3, 3'd5, 1'b1, 2'd0, 1'b1, 3'b000},
      {2'd1, 3'd3, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd1, 3'd2, 1'b0, 2'd0, 1'b0, 3'b000},
      {2'd1, 3'd1, 1'b0, 2'd0, 1'b0, 3'b000},
      {2'd2, 3'd2, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd1, 3'd3, 1'b0, 2'd1, 1'b1, 3'b000},
      {2'd0, 3'd0, 1'b1, 2'd0, 1'b0, 3'b000},
      {2'd2, 3'd0, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd2, 3'd6, 1'b0, 2'd0, 1'b1, 3'b011},
      {2'd1, 3'd3, 1'b0, 2'd2, 1'b1, 3'b000},
      {2'd3, 3'd5, 1'b1, 2'd0, 1'b0, 3'b000},
      {2'd3, 3'd5, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd2, 3'd5, 1'b1, 2'd0, 1'b1, 3'b000},
      {2'd3, 3'd2, 1'b0, 2'd0, 1'b0, 3'b000},
      {2'd1, 3'd6, 1'b0, 2'd0, 1'b0, 3'b000},
      {2'd0, 3'd7, 1'b0, 2'd0, 1'b0, 3'b000},
      {2'd1, 3'd3, 1'b0, 2'd3, 1'b0, 3'b000},
      {2'd0, 3'd4, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd2, 3'd6, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd0, 3'd0, 1'b0, 2'd0, 1'b1, 3'b000},
      {2'd1, 3'd2, 1'b0, 2'd0, 1'b1, 3'b000}
   };

   function automatic string tag_of(input logic [1:0] m, input logic [2:0] o, input logic e);
      if (o == 3'd6)                        return "R7";
      if (m == 2'd2 && !(o == 3'd0 && e))   return "R5";
      if (o == 3'd0 && e && m[1])           return "R6";
      if (o == 3'd0)                        return "R3";
      if (o == 3'd5)                        return "R4";
      if (o == 3'd4)                        return "R9";
      if (o == 3'd1 || o == 3'd2)           return (m == 2'd3) ? "R8" : "R2";
      return "R8";
   endfunction

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive at a negedge, sample at the next negedge (one posedge later)
   task automatic issue(input logic [1:0] m, input logic [2:0] o, input logic e,
                        input logic [1:0] s, input logic clr);
      req_valid = 1'b1; req_mode = m; req_op = o; req_ext = e; req_sel = s; viol_clr = clr;
      @(negedge clk);
      req_valid = 1'b0; viol_clr = 1'b0;
   endtask

   task automatic idle(input logic clr);
      viol_clr = clr;
      @(negedge clk);
      viol_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11", {rsp_valid, rsp_grant, rsp_bits}, 5'b00000);
      check("R11", {4'b0, viol}, 5'b0);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][11:10], VEC[i][9:7], VEC[i][6], VEC[i][5:4], 1'b0);
         check(tag_of(VEC[i][11:10], VEC[i][9:7], VEC[i][6]),
               {rsp_valid, rsp_grant, rsp_bits}, {1'b1, VEC[i][3], VEC[i][2:0]});
      end

      // R10 sticky after denials in the table
      check("R10", {4'b0, viol}, 5'b1);
      // R1 no request -> no response
      idle(1'b0);
      check("R1", {rsp_valid, rsp_grant, rsp_bits}, 5'b00000);
      check("R10", {4'b0, viol}, 5'b1);
      // R10 clear alone
      idle(1'b1);
      check("R10", {4'b0, viol}, 5'b0);
      // R10 clear with denial on the same edge: set wins
      issue(2'd3, 3'd2, 1'b0, 2'd0, 1'b1);
      check("R10", {rsp_valid, rsp_grant, 2'b0, viol}, 5'b10001);
      // R10 clear with a granted request: flag drops
      issue(2'd2, 3'd0, 1'b0, 2'd0, 1'b1);
      check("R10", {rsp_valid, rsp_grant, 2'b0, viol}, 5'b11000);
      // R8 program read lock, query next cycle sees it
      issue(2'd2, 3'd3, 1'b0, 2'd1, 1'b0);
      issue(2'd2, 3'd6, 1'b0, 2'd0, 1'b0);
      check("R8", {rsp_valid, rsp_grant, rsp_bits}, 5'b11010);
      // R3 read lock honours reads with req_ext=1 in programmer mode too
      issue(2'd1, 3'd0, 1'b1, 2'd0, 1'b0);
      check("R3", {rsp_valid, rsp_grant, rsp_bits}, 5'b10000);
      // R11 reset reloads bits from RESET_BITS (0)
      rst_n = 1'b0;
      @(negedge clk);
      check("R11", {rsp_valid, rsp_grant, rsp_bits}, 5'b00000);
      rst_n = 1'b1;
      @(negedge clk);
      issue(2'd2, 3'd6, 1'b0, 2'd0, 1'b0);
      check("R11", {rsp_valid, rsp_grant, rsp_bits}, 5'b11000);
      check("R11", {4'b0, viol}, 5'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule